// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder

This block turns one 4-bit binary-coded-decimal digit into the seven segment drives of a common-anode LED display. The segment outputs are active low: a 0 lights a segment and a 1 leaves it dark. Codes 10 to 15 are not decimal digits, so they leave the display dark.

Three active-low control inputs sit on top of the digit decoding. Blanking darkens the whole digit and wins over every other input. Lamp test lights every segment. The ripple input suppresses a leading zero. When a zero is suppressed, the ripple output goes low. Wiring that output to the ripple input of the next lower-order digit chains zero suppression along a row of digits.

The block is purely combinational. It has no clock and no state.

Top module: `bcd7_driver`

## Requirements
- R1: `seg_n` bit 0 drives segment a, bit 1 drives b, and so on up to bit 6, which drives g. Each bit is active low: 0 lights the segment and 1 leaves it dark.
- R2: When `blank_n`=1, `lamp_test_n`=1 and zero suppression is not active, each digit lights exactly these segments:
  - 0: a b c d e f
  - 1: b c
  - 2: a b d e g
  - 3: a b c d g
  - 4: b c f g
  - 5: a c d f g
  - 6: a c d e f g
  - 7: a b c
  - 8: all seven
  - 9: a b c d f g
- R3: With `blank_n`=1 and `lamp_test_n`=1, input codes 10 to 15 drive all seven `seg_n` bits to 1.
- R4: `blank_n`=0 drives `seg_n` to 7'h7F and `ripple_out_n` to 1, whatever the other inputs are.
- R5: `blank_n`=1 with `lamp_test_n`=0 drives `seg_n` to 7'h00 and `ripple_out_n` to 1, whatever `bcd_in` and `ripple_in_n` are.
- R6: `blank_n`=1, `lamp_test_n`=1, `ripple_in_n`=0 and `bcd_in`=0 together drive `seg_n` to 7'h7F and `ripple_out_n` to 0.
- R7: In every other input case `ripple_out_n` is 1. A low `ripple_in_n` has no effect on the segments for codes 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_in | input | 4 | BCD digit code |
| lamp_test_n | input | 1 | Active-low lamp test; lights all segments |
| blank_n | input | 1 | Active-low blanking; highest priority |
| ripple_in_n | input | 1 | Active-low ripple input; suppresses a zero |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| ripple_out_n | output | 1 | Active-low ripple output; low when a zero was suppressed |

## Verification
The assertions take for granted that every input is a settled 0 or 1 when they are evaluated. They check only after the combinational outputs have resolved from the current inputs. The stimulus meets this by changing inputs one complete vector at a time and holding each vector for a full clock period. No X or Z is driven once the first vector has been applied. The stimulus walks all 128 combinations of the code and the three control inputs, so every priority pairing reaches the checker.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int CODE_W    = 4;
  localparam int NSEG      = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [NSEG-1:0]   seg_t;
  typedef logic [CODE_W-1:0] code_t;

  // Lit-segment mask for a decimal digit: bit 0 = a ... bit 6 = g, 1 = lit.
  function automatic seg_t digit_lit(input code_t code);
    seg_t m;
    case (code)
      4'd0:    m = 7'b0111111;
      4'd1:    m = 7'b0000110;
      4'd2:    m = 7'b1011011;
      4'd3:    m = 7'b1001111;
      4'd4:    m = 7'b1100110;
      4'd5:    m = 7'b1101101;
      4'd6:    m = 7'b1111101;
      4'd7:    m = 7'b0000111;
      4'd8:    m = 7'b1111111;
      4'd9:    m = 7'b1101111;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic code_valid(input code_t code);
    return code <= code_t'(MAX_DIGIT);
  endfunction
endpackage

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
  import bcd7_pkg::*;
(
  input  code_t code,
  output logic  valid,
  output logic  is_zero,
  output seg_t  lit
);
  always_comb begin
    valid   = code_valid(code);
    is_zero = (code == '0);
    lit     = valid ? digit_lit(code) : '0;
  end
endmodule

// File: rtl/bcd7_ctl.sv
module bcd7_ctl (
  input  logic blank_n,
  input  logic lamp_test_n,
  input  logic ripple_in_n,
  input  logic is_zero,
  output logic force_dark,
  output logic force_lit,
  output logic zero_sup
);
  always_comb begin
    force_dark = ~blank_n;
    force_lit  = blank_n & ~lamp_test_n;
    zero_sup   = blank_n & lamp_test_n & ~ripple_in_n & is_zero;
  end
endmodule

// File: rtl/bcd7_out.sv
module bcd7_out
  import bcd7_pkg::*;
(
  input  seg_t lit,
  input  logic force_dark,
  input  logic force_lit,
  input  logic zero_sup,
  output seg_t seg_n
);
  logic dark_all;
  assign dark_all = force_dark | zero_sup;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_comb begin
      if (dark_all)       seg_n[i] = 1'b1;
      else if (force_lit) seg_n[i] = 1'b0;
      else                seg_n[i] = ~lit[i];
    end
  end
endmodule

// File: rtl/bcd7_driver.sv
module bcd7_driver
  import bcd7_pkg::*;
(
  input  logic [3:0] bcd_in,
  input  logic       lamp_test_n,
  input  logic       blank_n,
  input  logic       ripple_in_n,
  output logic [6:0] seg_n,
  output logic       ripple_out_n
);
  logic code_ok;
  logic code_zero;
  seg_t glyph_lit;
  logic force_dark;
  logic force_lit;
  logic zero_sup;

  bcd7_glyph u_glyph (
    .code    (bcd_in),
    .valid   (code_ok),
    .is_zero (code_zero),
    .lit     (glyph_lit)
  );

  bcd7_ctl u_ctl (
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .ripple_in_n (ripple_in_n),
    .is_zero     (code_zero),
    .force_dark  (force_dark),
    .force_lit   (force_lit),
    .zero_sup    (zero_sup)
  );

  bcd7_out u_out (
    .lit        (glyph_lit),
    .force_dark (force_dark),
    .force_lit  (force_lit),
    .zero_sup   (zero_sup),
    .seg_n      (seg_n)
  );

  assign ripple_out_n = ~zero_sup;
endmodule

// File: rtl/bcd7_driver_chk.sv
module bcd7_driver_chk (
  input logic [3:0] bcd_in,
  input logic       lamp_test_n,
  input logic       blank_n,
  input logic       ripple_in_n,
  input logic [6:0] seg_n,
  input logic       ripple_out_n,
  input logic       code_ok,
  input logic [6:0] glyph_lit
);
  always_comb begin
    if (!$isunknown({bcd_in, lamp_test_n, blank_n, ripple_in_n})) begin
      AST_BLANK_DARK: assert (blank_n || (seg_n == 7'h7F && ripple_out_n)); // R4
      AST_LAMP_LIT: assert (!blank_n || lamp_test_n || (seg_n == 7'h00 && ripple_out_n)); // R5
      AST_INVALID_DARK: assert (!blank_n || !lamp_test_n || code_ok || seg_n == 7'h7F); // R3
      AST_RIPPLE_CAUSE: assert (ripple_out_n || (bcd_in == 4'd0 && !ripple_in_n && lamp_test_n && blank_n)); // R7
      AST_RIPPLE_DARK: assert (ripple_out_n || seg_n == 7'h7F); // R6
      AST_GLYPH_PASS: assert (!blank_n || !lamp_test_n || !ripple_out_n || seg_n == ~glyph_lit); // R2
    end
  end
endmodule

bind bcd7_driver bcd7_driver_chk u_chk (
  .bcd_in       (bcd_in),
  .lamp_test_n  (lamp_test_n),
  .blank_n      (blank_n),
  .ripple_in_n  (ripple_in_n),
  .seg_n        (seg_n),
  .ripple_out_n (ripple_out_n),
  .code_ok      (code_ok),
  .glyph_lit    (glyph_lit)
);

// File: tb/bcd7_driver_bench.sv
`timescale 1ns/1ps
module bcd7_driver_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0] bcd_in;
  logic       lamp_test_n, blank_n, ripple_in_n;
  logic [6:0] seg_n;
  logic       ripple_out_n;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  bcd7_driver u_bcd7_driver (
    .bcd_in(bcd_in), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .ripple_in_n(ripple_in_n), .seg_n(seg_n), .ripple_out_n(ripple_out_n)
  );

  // R2 glyphs spelled as segment letters; unlisted codes light nothing (R3).
  localparam string GLYPH [16] = '{
    "abcdef", "bc", "abdeg", "abcdg", "bcfg", "acdfg", "acdefg", "abc",
    "abcdefg", "abcdfg", "", "", "", "", "", ""
  };

  // R1: letter a maps to bit 0 through letter g to bit 6, and a lit segment is 0.
  function automatic logic [6:0] active_low_from(string s);
    logic [6:0] v = 7'h7F;
    for (int k = 0; k < s.len(); k++) v[s[k] - "a"] = 1'b0;
    return v;
  endfunction

  task automatic apply(input logic [3:0] c, input logic lt, input logic bi,
                       input logic rbi);
    @(posedge clk);
    bcd_in = c; lamp_test_n = lt; blank_n = bi; ripple_in_n = rbi;
    #5;
  endtask

  task automatic check(input string req, input logic [6:0] exp_seg,
                       input logic exp_rbo);
    n_vec++;
    if (seg_n !== exp_seg || ripple_out_n !== exp_rbo) begin
      n_bad++;
      $display("FAIL %s code=%0d lt=%b bi=%b rbi=%b: seg_n=%h rbo=%b expected seg_n=%h rbo=%b",
               req, bcd_in, lamp_test_n, blank_n, ripple_in_n, seg_n,
               ripple_out_n, exp_seg, exp_rbo);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bcd_in = 4'd8; lamp_test_n = 1'b1; blank_n = 1'b0; ripple_in_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    check("R4 reset-dark", 7'h7F, 1'b1);
    rst = 1'b0;

    // Exhaustive walk over every combination of code and control inputs.
    for (int v = 0; v < 128; v++) begin
      logic [3:0] c;
      logic lt, bi, rbi;
      logic [6:0] es;
      logic er;
      string req;
      c = v[3:0]; lt = v[4]; bi = v[5]; rbi = v[6];
      apply(c, lt, bi, rbi);
      if (!bi) begin
        es = 7'h7F; er = 1'b1; req = "R4";
      end else if (!lt) begin
        es = 7'h00; er = 1'b1; req = "R5";
      end else if (!rbi && c == 4'd0) begin
        es = 7'h7F; er = 1'b0; req = "R6";
      end else begin
        es = active_low_from(GLYPH[c]); er = 1'b1;
        req = (c > 4'd9) ? "R3" : "R2 R7";
      end
      check(req, es, er);
    end

    // Directed corner cases.
    apply(4'd5, 1'b1, 1'b1, 1'b1); check("R1 digit5", 7'b0010010, 1'b1);
    apply(4'd9, 1'b1, 1'b1, 1'b1); check("R1 digit9", 7'b0010000, 1'b1);
    apply(4'd0, 1'b1, 1'b1, 1'b1); check("R2 zero-shown", 7'b1000000, 1'b1);
    apply(4'd0, 1'b1, 1'b1, 1'b0); check("R6 zero-suppressed", 7'h7F, 1'b0);
    apply(4'd1, 1'b1, 1'b1, 1'b0); check("R7 rbi-ignored-nonzero", 7'b1111001, 1'b1);
    apply(4'd15, 1'b1, 1'b1, 1'b0); check("R7 rbi-invalid", 7'h7F, 1'b1);
    apply(4'd0, 1'b0, 1'b1, 1'b0); check("R5 lamp-over-ripple", 7'h00, 1'b1);
    apply(4'd0, 1'b0, 1'b0, 1'b0); check("R4 blank-over-all", 7'h7F, 1'b1);
    apply(4'd12, 1'b0, 1'b1, 1'b1); check("R5 lamp-invalid", 7'h00, 1'b1);
    apply(4'd10, 1'b1, 1'b1, 1'b1); check("R3 code10", 7'h7F, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule